// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the master side of a four-wire serial link to a byte-addressed EEPROM. A host asks for one of four operations: read the status byte, write the status byte, write a run of data bytes, or read a run of data bytes. It supplies the operation code, a three-byte start address and a byte count, then pulses a start strobe. The block builds the whole transaction on the wire. It lowers the select line, shifts out the opcode and address, then moves the data. Write data comes in on one byte stream and read data goes out on another, and both use a valid/ready handshake.

Before any operation that changes the device, the block sends the write-enable command in a separate select frame. After the write frame ends, it polls the device status until the write-in-progress bit clears. Only then does it drop `busy`. If the device stays busy for a configured number of polls, the block gives up, raises `err` and returns to idle. The serial clock is the system clock divided by an even parameter. The link runs in clock mode 0 (idle low, sample on the rising edge) with the most significant bit first.

Top module: `spi_rom_sequencer`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, and `busy`, `err`, `wr_ready` and `rd_valid` are all 0.
- R2: Command bytes are 0x05 to read status, 0x01 to write status, 0x06 for write enable, 0x02 to write data and 0x03 to read data. The host `op` encoding is 0 = status read, 1 = status write, 2 = data write, 3 = data read.
- R3: A data write or data read sends its opcode and then the address as three bytes, bits 23:16 first, then 15:8, then 7:0, before any data byte.
- R4: Every status write and every data write is preceded by a frame that holds only 0x06. Status reads and data reads get no such frame.
- R5: After a write frame, the block sends status-read frames (0x05 plus one byte) until bit 0 of the returned status is 0. `busy` stays 1 until that poll has finished.
- R6: `sck` idles low and is only active while `cs_n` is 0. Bytes go out MSB first, and `mosi` does not change on the rising edge, where both sides sample.
- R7: Every byte the block only receives (status data, read data) is sent on `mosi` as 0xFF.
- R8: `cs_n` stays low from the opcode through the last data byte of a frame. It is high whenever `busy` is 0.
- R9: `sck` is low in the cycle in which `cs_n` changes and in the cycle before it.
- R10: `sck` stays high for exactly DIV/2 system clock cycles on every pulse.
- R11: If POLL_MAX consecutive polls all return bit 0 = 1, the block sets `err` and returns to idle. A new start clears `err`.
- R12: A status read delivers exactly one byte on the read stream. A status write sends exactly one data byte after 0x01, taken from the write stream.
- R13: Write bytes are consumed only on `wr_valid && wr_ready`. `rd_data` holds steady while `rd_valid && !rd_ready`. `busy` stays 1 until the last read byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken while idle |
| op | input | 2 | Operation: 0 status read, 1 status write, 2 data write, 3 data read |
| addr | input | 24 | Start address for data operations |
| len | input | 16 | Number of data bytes for data operations |
| busy | output | 1 | High while an operation is in progress |
| err | output | 1 | Set when the busy-poll limit is reached |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Block accepts the write stream byte |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte present |
| rd_ready | input | 1 | Host accepts the read stream byte |
| cs_n | output | 1 | Device select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The properties assume that `rst_n` is low from time zero and that `miso` is settled before every rising `sck` edge. The bench's device model meets the second assumption by changing `miso` only on falling `sck` edges. The hold property on the read stream assumes that the host drops `rd_ready` only between handshakes. The bench's read collector therefore changes `rd_ready` on the falling system clock edge, following a fixed stall pattern. Host requests are issued only while `busy` is low, so no property relies on a start that arrives mid-operation.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;
   typedef enum logic [1:0] {
      OP_STAT_RD = 2'd0,
      OP_STAT_WR = 2'd1,
      OP_DATA_WR = 2'd2,
      OP_DATA_RD = 2'd3
   } host_op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WREN, ST_GAP, ST_HDR, ST_TXD, ST_RXD, ST_POLL, ST_FIN
   } seq_state_e;

   localparam logic [7:0] CMD_RDSR  = 8'h05;
   localparam logic [7:0] CMD_WRSR  = 8'h01;
   localparam logic [7:0] CMD_WREN  = 8'h06;
   localparam logic [7:0] CMD_WRITE = 8'h02;
   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] FILL_BYTE = 8'hFF;

   function automatic logic [7:0] cmd_for(host_op_e o);
      case (o)
         OP_STAT_RD: return CMD_RDSR;
         OP_STAT_WR: return CMD_WRSR;
         OP_DATA_WR: return CMD_WRITE;
         default:    return CMD_READ;
      endcase
   endfunction

   function automatic logic op_writes(host_op_e o);
      return (o == OP_STAT_WR) || (o == OP_DATA_WR);
   endfunction
endpackage

// File: rtl/spi_rom_clkdiv.sv
module spi_rom_clkdiv #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (!en)                     cnt <= '0;
      else if (cnt == CW'(HALF - 1))    cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/spi_rom_shifter.sv
module spi_rom_shifter #(
   parameter int DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       done,
   output logic [7:0] rx,
   output logic       sck,
   output logic       mosi
);
   logic       tick;
   logic       run_q, sck_q, done_q;
   logic [7:0] tsr, rsr;
   logic [3:0] bitn;

   spi_rom_clkdiv #(.DIV(DIV)) i_div (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (run_q),
      .tick (tick)
   );

   // Mode 0: data set up while SCK is low, captured on the rise, advanced on the fall.
   // One trailing half period after the last fall keeps SCK low around a select change.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
         tsr    <= '0;
         rsr    <= '0;
         bitn   <= '0;
      end else begin
         done_q <= 1'b0;
         if (go && !run_q) begin
            tsr   <= tx;
            run_q <= 1'b1;
            bitn  <= '0;
            sck_q <= 1'b0;
         end else if (run_q && tick) begin
            if (bitn == 4'd8) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end else if (!sck_q) begin
               sck_q <= 1'b1;
               rsr   <= {rsr[6:0], miso};
            end else begin
               sck_q <= 1'b0;
               bitn  <= bitn + 1'b1;
               tsr   <= {tsr[6:0], 1'b0};
            end
         end
      end
   end

   assign done = done_q;
   assign rx   = rsr;
   assign sck  = sck_q;
   assign mosi = tsr[7];
endmodule

// File: rtl/spi_rom_sequencer.sv
module spi_rom_sequencer
   import spi_rom_pkg::*;
#(
   parameter int DIV        = 4,
   parameter int POLL_MAX   = 64,
   parameter int ADDR_BYTES = 3,
   parameter int LEN_W      = 16,
   parameter int GAP_CYC    = DIV
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [1:0]              op,
   input  logic [8*ADDR_BYTES-1:0] addr,
   input  logic [LEN_W-1:0]        len,
   output logic                    busy,
   output logic                    err,
   input  logic [7:0]              wr_data,
   input  logic                    wr_valid,
   output logic                    wr_ready,
   output logic [7:0]              rd_data,
   output logic                    rd_valid,
   input  logic                    rd_ready,
   output logic                    cs_n,
   output logic                    sck,
   output logic                    mosi,
   input  logic                    miso
);
   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int HW     = $clog2(ADDR_BYTES + 1);
   localparam int PW     = $clog2(POLL_MAX + 1);
   localparam int GW     = $clog2(GAP_CYC + 1);

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("spi_rom_sequencer: DIV must be even and at least 2");
   end
   if (POLL_MAX < 1) begin : g_bad_poll
      $error("spi_rom_sequencer: POLL_MAX must be at least 1");
   end
   if (ADDR_BYTES < 1 || GAP_CYC < 1) begin : g_bad_geom
      $error("spi_rom_sequencer: ADDR_BYTES and GAP_CYC must be positive");
   end

   seq_state_e        state, ret;
   host_op_e          op_q;
   logic [ADDR_W-1:0] asr;
   logic [HW-1:0]     hidx, hdr_last;
   logic [LEN_W-1:0]  dcnt;
   logic [PW-1:0]     pcnt;
   logic [GW-1:0]     gcnt;
   logic              wait_sh, pidx, cs_q, err_q, rdv_q;
   logic [7:0]        rdd_q;

   logic              sh_go, sh_done, last_byte, fin_byte;
   logic [7:0]        sh_tx, sh_rx;

   spi_rom_shifter #(.DIV(DIV)) i_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (sh_go),
      .tx   (sh_tx),
      .miso (miso),
      .done (sh_done),
      .rx   (sh_rx),
      .sck  (sck),
      .mosi (mosi)
   );

   assign hdr_last = op_q[1] ? HW'(ADDR_BYTES) : '0;
   assign fin_byte = wait_sh && sh_done;

   always_comb begin
      sh_go = 1'b0;
      sh_tx = FILL_BYTE;
      unique case (state)
         ST_WREN: begin sh_tx = CMD_WREN; sh_go = !wait_sh; end
         ST_HDR:  begin
            sh_tx = (hidx == '0) ? cmd_for(op_q) : asr[ADDR_W-1 -: 8];
            sh_go = !wait_sh;
         end
         ST_TXD:  begin sh_tx = wr_data; sh_go = !wait_sh && wr_valid; end
         ST_RXD:  sh_go = !wait_sh && !rdv_q;
         ST_POLL: begin sh_tx = pidx ? FILL_BYTE : CMD_RDSR; sh_go = !wait_sh; end
         default: ;
      endcase
   end

   always_comb begin
      last_byte = 1'b0;
      if (fin_byte) begin
         if (state == ST_HDR)
            last_byte = (hidx == hdr_last) && (dcnt == '0);
         else if (state == ST_TXD || state == ST_RXD)
            last_byte = (dcnt == LEN_W'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ret     <= ST_IDLE;
         op_q    <= OP_STAT_RD;
         asr     <= '0;
         hidx    <= '0;
         dcnt    <= '0;
         pcnt    <= '0;
         gcnt    <= '0;
         wait_sh <= 1'b0;
         pidx    <= 1'b0;
         cs_q    <= 1'b1;
         err_q   <= 1'b0;
         rdv_q   <= 1'b0;
         rdd_q   <= '0;
      end else begin
         if (rdv_q && rd_ready) rdv_q <= 1'b0;
         if (sh_go)    wait_sh <= 1'b1;
         if (fin_byte) wait_sh <= 1'b0;

         unique case (state)
            ST_IDLE: if (start) begin
               op_q  <= host_op_e'(op);
               asr   <= addr;
               dcnt  <= op[1] ? len : LEN_W'(1);
               err_q <= 1'b0;
               hidx  <= '0;
               cs_q  <= 1'b0;
               state <= op_writes(host_op_e'(op)) ? ST_WREN : ST_HDR;
            end
            ST_WREN: if (fin_byte) begin
               cs_q  <= 1'b1;
               gcnt  <= '0;
               ret   <= ST_HDR;
               state <= ST_GAP;
            end
            ST_GAP: begin
               if (gcnt == GW'(GAP_CYC - 1)) begin
                  cs_q  <= 1'b0;
                  pidx  <= 1'b0;
                  state <= ret;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            ST_HDR: if (fin_byte) begin
               if (hidx == hdr_last) begin
                  hidx  <= '0;
                  state <= op_writes(op_q) ? ST_TXD : ST_RXD;
               end else begin
                  hidx <= hidx + 1'b1;
               end
               if (hidx != '0) asr <= asr << 8;
            end
            ST_TXD: if (fin_byte) dcnt <= dcnt - 1'b1;
            ST_RXD: if (fin_byte) begin
               rdv_q <= 1'b1;
               rdd_q <= sh_rx;
               dcnt  <= dcnt - 1'b1;
            end
            ST_POLL: if (fin_byte) begin
               if (!pidx) begin
                  pidx <= 1'b1;
               end else begin
                  cs_q <= 1'b1;
                  pidx <= 1'b0;
                  if (!sh_rx[0]) begin
                     state <= ST_FIN;
                  end else if (pcnt == PW'(POLL_MAX - 1)) begin
                     err_q <= 1'b1;
                     state <= ST_FIN;
                  end else begin
                     pcnt  <= pcnt + 1'b1;
                     gcnt  <= '0;
                     ret   <= ST_POLL;
                     state <= ST_GAP;
                  end
               end
            end
            ST_FIN: if (!rdv_q) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase

         if (last_byte) begin
            cs_q <= 1'b1;
            if (op_writes(op_q)) begin
               pcnt  <= '0;
               gcnt  <= '0;
               ret   <= ST_POLL;
               state <= ST_GAP;
            end else begin
               state <= ST_FIN;
            end
         end
      end
   end

   assign busy     = (state != ST_IDLE);
   assign err      = err_q;
   assign cs_n     = cs_q;
   assign wr_ready = (state == ST_TXD) && !wait_sh;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;
endmodule

// File: rtl/spi_rom_sequencer_chk.sv
module spi_rom_sequencer_chk #(
   parameter int DIV = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       err,
   input logic       cs_n,
   input logic       sck,
   input logic       mosi,
   input logic       wr_ready,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic [7:0] rd_data
);
   localparam int HALF = DIV / 2;
   localparam int HCW  = $clog2(DIV + 1);

   logic           sck_d;
   logic [HCW-1:0] hcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         hcnt  <= '0;
      end else begin
         sck_d <= sck;
         if (sck != sck_d)              hcnt <= '0;
         else if (hcnt != {HCW{1'b1}})  hcnt <= hcnt + 1'b1;
      end
   end

   p_select_quiet_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n != $past(cs_n)) |-> (!sck && !$past(sck)));

   p_idle_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   p_clock_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !cs_n);

   p_mosi_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi));

   p_high_time_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> (hcnt == HCW'(HALF - 1)));

   p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   p_wr_ready_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> busy);

   p_err_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> !err);
endmodule

bind spi_rom_sequencer spi_rom_sequencer_chk #(.DIV(DIV)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .err     (err),
   .cs_n    (cs_n),
   .sck     (sck),
   .mosi    (mosi),
   .wr_ready(wr_ready),
   .rd_valid(rd_valid),
   .rd_ready(rd_ready),
   .rd_data (rd_data)
);

// File: tb/test_spi_rom_sequencer.sv
`timescale 1ns/1ps
module test_spi_rom_sequencer;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam int PMAX = 8;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [1:0]  op = '0;
   logic [23:0] addr = '0;
   logic [15:0] len = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_valid = 1'b0, rd_ready = 1'b0;
   logic        busy, err, wr_ready, rd_valid, cs_n, sck, mosi, miso;
   logic [7:0]  rd_data;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   spi_rom_sequencer #(.DIV(DIV), .POLL_MAX(PMAX)) i_spi_rom_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .len(len),
      .busy(busy), .err(err), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
   );

   // ---------------- device model ----------------
   bit [7:0]  mem [256];
   bit [7:0]  nv = 0, cur_op = 0, prev_op = 0, rx_sr = 0, out_sr = 0, nxt = 0;
   bit        wel = 0, load = 0, p_sck = 0, p_cs = 1;
   bit [23:0] hdr_addr = 0, last_addr = 0;
   int        wip_cnt = 0, busy_len = 0, bitc = 0, fi = 0;
   int        polls = 0, wrsr_bytes = 0, bad_wr = 0, bad_dummy = 0;
   int        bad_cs = 0, bad_tim = 0, n_wren = 0, n_frames = 0;
   time       t_rise = 0;

   assign miso = out_sr[7];

   task automatic byte_done(input bit [7:0] b);
      if (fi == 0) begin
         cur_op = b;
         if (b == 8'h01) wrsr_bytes = 0;
         if (b == 8'h05) begin nxt = {nv[7:2], wel, wip_cnt != 0}; load = 1; end
      end else begin
         case (cur_op)
            8'h05: if (b != 8'hFF) bad_dummy++;
            8'h01: begin wrsr_bytes++; if (fi == 1) nv = b & 8'h8C; end
            8'h02: begin
               if (fi <= 3) begin
                  hdr_addr = {hdr_addr[15:0], b};
                  if (fi == 3) last_addr = hdr_addr;
               end else begin
                  mem[hdr_addr[7:0]] = b;
                  hdr_addr++;
               end
            end
            8'h03: begin
               if (fi <= 3) begin
                  hdr_addr = {hdr_addr[15:0], b};
                  if (fi == 3) last_addr = hdr_addr;
               end else if (b != 8'hFF) bad_dummy++;
               if (fi >= 3) begin nxt = mem[hdr_addr[7:0]]; hdr_addr++; load = 1; end
            end
            default: ;
         endcase
      end
   endtask

   task automatic frame_end;
      n_frames++;
      case (cur_op)
         8'h06: begin wel = 1; n_wren++; end
         8'h01, 8'h02: begin
            if (prev_op != 8'h06 || !wel) bad_wr++;
            wel = 0; wip_cnt = busy_len; polls = 0;
         end
         8'h05: begin polls++; if (wip_cnt > 0) wip_cnt--; end
         default: ;
      endcase
      prev_op = cur_op;
   endtask

   always @(sck or cs_n) begin
      if (rst_n) begin
         if (cs_n !== p_cs && sck === 1'b1) bad_cs++;
         if (cs_n === 1'b0 && p_cs) begin fi = 0; bitc = 0; out_sr = 0; load = 0; cur_op = 0; end
         if (cs_n === 1'b1 && !p_cs) frame_end();
         if (cs_n === 1'b0 && sck === 1'b1 && !p_sck) begin
            t_rise = $time;
            rx_sr  = {rx_sr[6:0], mosi};
            bitc++;
            if (bitc == 8) begin bitc = 0; byte_done(rx_sr); fi++; end
         end
         if (cs_n === 1'b0 && sck === 1'b0 && p_sck) begin
            if ($time - t_rise != HALF * 4) bad_tim++;
            if (load) begin out_sr = nxt; load = 0; end
            else out_sr = {out_sr[6:0], 1'b0};
         end
      end
      p_sck = (sck === 1'b1);
      p_cs  = (cs_n !== 1'b0);
   end

   // ---------------- host helpers ----------------
   logic [7:0] rbuf [16];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
      return seed + 8'(i * 37);
   endfunction

   task automatic issue(input logic [1:0] o, input logic [23:0] a, input logic [15:0] l);
      @(negedge clk);
      op = o; addr = a; len = l; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic feed(input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_valid = 1'b1; wr_data = pat(seed, i);
         while (!wr_ready) @(negedge clk);
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic collect(input int n, input int stall);
      int k = 0, c = 0;
      while (k < n) begin
         @(negedge clk);
         c++;
         rd_ready = (stall == 0) || (c % stall != 0);
         if (rd_valid && rd_ready) begin rbuf[k] = rd_data; k++; end
      end
      @(negedge clk);
      rd_ready = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk("R1 cs_n", cs_n, 1);       chk("R1 sck", sck, 0);
      chk("R1 busy", busy, 0);       chk("R1 err", err, 0);
      chk("R1 wr_ready", wr_ready, 0); chk("R1 rd_valid", rd_valid, 0);
   endtask

   task automatic t_status_write;
      int w0 = n_wren;
      busy_len = 2;
      fork issue(2'd1, 24'h0, 16'd0); feed(1, 8'hFF); join
      chk("R4 wren frame before status write", n_wren - w0, 1);
      chk("R4 wren order", bad_wr, 0);
      chk("R12 one data byte after 0x01", wrsr_bytes, 1);
      chk("R2 status write opcode took effect", nv, 8'h8C);
      chk("R5 polls until ready", polls, 3);
      chk("R11 no error", err, 0);
   endtask

   task automatic t_status_read;
      int w0 = n_wren, p0 = polls;
      fork issue(2'd0, 24'h0, 16'd0); collect(1, 0); join
      chk("R12 status byte on read stream", rbuf[0], 8'h8C);
      chk("R12 single status frame", polls - p0, 1);
      chk("R4 no wren before read", n_wren - w0, 0);
      chk("R7 dummy bytes", bad_dummy, 0);
      chk("R13 busy low after accept", busy, 0);
   endtask

   task automatic t_write_burst;
      int f0 = n_frames;
      busy_len = 3;
      fork issue(2'd2, 24'h123456, 16'd5); feed(5, 8'h30); join
      chk("R3 address order", last_addr, 24'h123456);
      for (int i = 0; i < 5; i++) chk("R13 written data", mem[8'h56 + i], pat(8'h30, i));
      chk("R5 polls until ready", polls, 4);
      chk("R8 frame count wren+write+polls", n_frames - f0, 6);
      chk("R4 wren order", bad_wr, 0);
   endtask

   task automatic t_read_burst(input logic [23:0] a, input int n, input int stall, input int off);
      fork issue(2'd3, a, 16'(n)); collect(n, stall); join
      chk("R3 address order", last_addr, a);
      for (int i = 0; i < n; i++) chk("R13 read data", rbuf[i], pat(8'h30, off + i));
      chk("R7 dummy bytes", bad_dummy, 0);
   endtask

   task automatic t_timeout;
      busy_len = 100;
      fork issue(2'd2, 24'h000010, 16'd1); feed(1, 8'h30); join
      chk("R11 error flag", err, 1);
      chk("R11 poll count", polls, PMAX);
      chk("R11 back to idle", busy, 0);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_status_write();
      t_status_read();
      t_write_burst();
      t_read_burst(24'h123456, 5, 3, 0);
      t_read_burst(24'hFFFF58, 2, 0, 2);
      t_timeout();
      chk("R9 select changes with clock low", bad_cs, 0);
      chk("R10 clock high time", bad_tim, 0);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog: actual busy=%0b expected 0", busy);
      finish_run();
   end
endmodule